// File: doc/BRIEF.md
# Watchdog Base Period Capture Sequencer

This block measures how long an external ramp takes to charge and turns that time into the base timeout of a watchdog. It works in units of a slow timeout-clock tick. It waits until the supervisor's own reset output is released, then asks the analog side to charge the ramp. It counts ticks until the ramp comparator reports that the threshold has been crossed. The tick count is kept with a half-tick offset added, so the stored period is in half-tick units and equals twice the whole-tick count plus one.

A measurement that is cut short by the supervisor reset is thrown away. A fresh measurement begins from zero the next time the reset is released. Two results are kept apart from normal timeouts. A count below a small threshold means the timing capacitor is missing, and is reported as a zero timeout. A count above the largest allowed period is reported as an infinite timeout, which disables the watchdog. Once a result is stored, it stays unchanged until the block's own reset. The valid output tells the watchdog when it may start using the period.

Top module: `wdcap_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it, `valid`, `charge_req`, `zero_flag` and `inf_flag` are 0 and `period` is 0.
- R2: While `sys_rst` is high and no result is stored, `charge_req` stays 0.
- R3: In the cycle after `sys_rst` is seen low with no result stored, `charge_req` goes to 1 and `valid` stays 0.
- R4: While `charge_req` is 1, each cycle with `tick` high and `ramp_hit` low adds one to a tick count N. `tick` is ignored in the cycle where `ramp_hit` is seen high.
- R5: In the cycle after `ramp_hit` is seen high during sampling, `valid` rises and `charge_req` falls. For ZERO_TICKS <= N <= MAX_TICKS, `period` = 2N+1 in half-tick units, and both flags are 0.
- R6: If `sys_rst` is high during sampling, `charge_req` drops in the next cycle and the count is discarded. The next release of `sys_rst` starts a new count from zero.
- R7: If N < ZERO_TICKS, `period` = 0 and `zero_flag` = 1 (open capacitor).
- R8: If N > MAX_TICKS, `period` is all ones and `inf_flag` = 1 (watchdog disabled). The count saturates, so a count that runs long keeps this result.
- R9: Once `valid` is 1, `period`, both flags and `valid` hold their values, and `charge_req` stays 0. Any `tick`, `ramp_hit` or `sys_rst` activity has no effect until `rst_n` is low again.
- R10: `valid` and `charge_req` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset of the block; starts a new capture cycle |
| sys_rst | input | 1 | Supervisor reset output is asserted (active high) |
| ramp_hit | input | 1 | Ramp comparator: threshold crossed |
| tick | input | 1 | One-cycle enable per timeout-clock tick |
| charge_req | output | 1 | Request to charge the ramp while sampling |
| period | output | CNT_W+1 | Stored base period in half-tick units |
| zero_flag | output | 1 | Result is a zero timeout |
| inf_flag | output | 1 | Result is an infinite timeout |
| valid | output | 1 | Stored result is ready for use |

## Verification
Capture runs are made with tick counts of zero, one, a few, exactly MAX_TICKS, one more than MAX_TICKS, and far beyond it. Together these separate the zero band, the normal band with its half-tick offset, the upper limit on the normal side, and the saturated infinite band. One run drives a tick in the same cycle as the comparator hit, which shows whether that last tick is counted by mistake. Another run raises the supervisor reset partway through counting, which shows whether the count restarts from zero or carries over. After a result is stored, ticks, comparator pulses and a supervisor reset are applied to show that the result is held.

// File: rtl/wdcap_pkg.sv
package wdcap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_DONE = 2'd2
    } cap_state_e;
endpackage

// File: rtl/wdcap_tick_counter.sv
module wdcap_tick_counter #(
    parameter int MAX_TICKS = 46,
    parameter int CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(MAX_TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.cnt = '0;
        end else if (inc && (s_q.cnt != SAT_VAL)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;

    // The count never goes past one above the largest normal period (R8)
    assert_cnt_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= SAT_VAL);

    // A clear always brings the count back to zero in the next cycle (R6)
    assert_clear_to_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.cnt == '0));
endmodule

// File: rtl/wdcap_quantizer.sv
module wdcap_quantizer #(
    parameter int ZERO_TICKS = 1,
    parameter int MAX_TICKS  = 46,
    parameter int CNT_W      = 6,
    localparam int PER_W     = CNT_W + 1
) (
    input  logic [CNT_W-1:0] ticks,
    output logic [PER_W-1:0] res_period,
    output logic             res_zero,
    output logic             res_inf
);
    localparam logic [CNT_W-1:0] ZERO_LIM = CNT_W'(ZERO_TICKS);
    localparam logic [CNT_W-1:0] MAX_LIM  = CNT_W'(MAX_TICKS);

    always_comb begin
        res_zero   = (ticks < ZERO_LIM);
        res_inf    = (ticks > MAX_LIM);
        res_period = {ticks, 1'b1};
        if (res_zero) begin
            res_period = '0;
        end else if (res_inf) begin
            res_period = '1;
        end
    end
endmodule

// File: rtl/wdcap_seq.sv
module wdcap_seq #(
    parameter int ZERO_TICKS = 1,
    parameter int MAX_TICKS  = 46,
    localparam int CNT_W     = $clog2(MAX_TICKS + 2),
    localparam int PER_W     = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_rst,
    input  logic             ramp_hit,
    input  logic             tick,
    output logic             charge_req,
    output logic [PER_W-1:0] period,
    output logic             zero_flag,
    output logic             inf_flag,
    output logic             valid
);
    import wdcap_pkg::*;

    typedef struct packed {
        cap_state_e       st;
        logic [PER_W-1:0] per;
        logic             zero;
        logic             inf;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt_val;
    logic [PER_W-1:0] q_period;
    logic             q_zero;
    logic             q_inf;

    assign cnt_clr = (s_q.st != ST_MEAS) || sys_rst;
    assign cnt_inc = (s_q.st == ST_MEAS) && tick && !ramp_hit;

    wdcap_tick_counter #(
        .MAX_TICKS(MAX_TICKS),
        .CNT_W    (CNT_W)
    ) u_counter (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .cnt  (cnt_val)
    );

    wdcap_quantizer #(
        .ZERO_TICKS(ZERO_TICKS),
        .MAX_TICKS (MAX_TICKS),
        .CNT_W     (CNT_W)
    ) u_quant (
        .ticks     (cnt_val),
        .res_period(q_period),
        .res_zero  (q_zero),
        .res_inf   (q_inf)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (!sys_rst) s_d.st = ST_MEAS;
            end
            ST_MEAS: begin
                if (sys_rst) begin
                    s_d.st = ST_IDLE;
                end else if (ramp_hit) begin
                    s_d.st   = ST_DONE;
                    s_d.per  = q_period;
                    s_d.zero = q_zero;
                    s_d.inf  = q_inf;
                end
            end
            ST_DONE: begin
                s_d = s_q;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, per: '0, zero: 1'b0, inf: 1'b0};
        else        s_q <= s_d;
    end

    assign charge_req = (s_q.st == ST_MEAS);
    assign valid      = (s_q.st == ST_DONE);
    assign period     = s_q.per;
    assign zero_flag  = s_q.zero;
    assign inf_flag   = s_q.inf;

    // Sampling and a stored result never coexist (R10)
    assert_valid_excl_charge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && charge_req));

    // No charge request while supervisor reset holds and nothing is stored (R2)
    assert_no_charge_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && !charge_req && !valid) |=> !charge_req);

    // Release of supervisor reset starts sampling (R3)
    assert_start_on_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_rst && !charge_req && !valid) |=> charge_req);

    // Reset during sampling aborts it (R6)
    assert_abort_drops_charge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (charge_req && sys_rst) |=> (!charge_req && !valid));

    // Comparator hit during sampling ends it with a result (R5)
    assert_hit_gives_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (charge_req && !sys_rst && ramp_hit) |=> (valid && !charge_req));

    // Stored result never changes (R9)
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> (valid && $stable(period) && $stable(zero_flag) && $stable(inf_flag)));

    // Zero result carries an empty period (R7)
    assert_zero_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
        zero_flag |-> (period == '0 && !inf_flag));

    // Infinite result carries an all-ones period (R8)
    assert_inf_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inf_flag |-> (period == '1));
endmodule

// File: tb/wdcap_seq_bench.sv
module wdcap_seq_bench;
    localparam int ZT    = 1;
    localparam int MT    = 46;
    localparam int CW    = $clog2(MT + 2);
    localparam int PW    = CW + 1;

    typedef struct packed {
        logic [PW-1:0] per;
        logic          zero;
        logic          inf;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sys_rst = 1'b1;
    logic          ramp_hit = 1'b0;
    logic          tick = 1'b0;
    logic          charge_req;
    logic [PW-1:0] period;
    logic          zero_flag;
    logic          inf_flag;
    logic          valid;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    bit   seen_valid = 1'b0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    wdcap_seq #(.ZERO_TICKS(ZT), .MAX_TICKS(MT)) u_wdcap_seq (
        .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .ramp_hit(ramp_hit),
        .tick(tick), .charge_req(charge_req), .period(period),
        .zero_flag(zero_flag), .inf_flag(inf_flag), .valid(valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic exp_t model(input int n);
        exp_t e;
        if (n < ZT)      e = '{per: '0, zero: 1'b1, inf: 1'b0};
        else if (n > MT) e = '{per: '1, zero: 1'b0, inf: 1'b1};
        else             e = '{per: PW'(2 * n + 1), zero: 1'b0, inf: 1'b0};
        return e;
    endfunction

    // Monitor: compares each new result against the scoreboard
    always @(negedge clk) begin
        if (!valid) seen_valid <= 1'b0;
        else if (!seen_valid) begin
            exp_t e;
            seen_valid <= 1'b1;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected result", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check(period == e.per, "R5/R7/R8 period", int'(period), int'(e.per));
                check(zero_flag == e.zero, "R7 zero_flag", int'(zero_flag), int'(e.zero));
                check(inf_flag == e.inf, "R8 inf_flag", int'(inf_flag), int'(e.inf));
                check(!charge_req, "R5 charge_req low with result", int'(charge_req), 0);
            end
        end
    end

    task automatic block_reset();
        @(negedge clk);
        rst_n = 1'b0; sys_rst = 1'b1; tick = 1'b0; ramp_hit = 1'b0;
        @(negedge clk);
        check(!valid && !charge_req && period == '0 && !zero_flag && !inf_flag,
              "R1 reset state", int'({valid, charge_req, zero_flag, inf_flag}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!valid && !charge_req, "R1/R2 idle after reset", int'({valid, charge_req}), 0);
    endtask

    task automatic release_sys();
        sys_rst = 1'b0;
        @(negedge clk);
        check(charge_req && !valid, "R3 sampling starts", int'({charge_req, valid}), 2);
    endtask

    task automatic send_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; @(negedge clk);
            tick = 1'b0; @(negedge clk);
        end
    endtask

    // Driver: one full capture with n counted ticks
    task automatic capture(input int n, input bit tick_on_hit);
        block_reset();
        exp_q.push_back(model(n));
        release_sys();
        send_ticks(n);
        ramp_hit = 1'b1; tick = tick_on_hit;
        @(negedge clk);
        ramp_hit = 1'b0; tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R2: no sampling while supervisor reset holds
        block_reset();
        repeat (5) @(negedge clk);
        check(!charge_req, "R2 held in supervisor reset", int'(charge_req), 0);

        capture(0, 1'b0);        // R7 open capacitor
        capture(1, 1'b0);        // R4/R5 smallest normal
        capture(5, 1'b0);        // R5
        capture(3, 1'b1);        // R4 tick on hit cycle ignored
        capture(MT, 1'b0);       // R5 upper limit
        capture(MT + 1, 1'b0);   // R8 just over limit
        capture(MT + 20, 1'b0);  // R8 saturated

        // R6: abort mid-count, restart from zero
        block_reset();
        exp_q.push_back(model(4));
        release_sys();
        send_ticks(10);
        sys_rst = 1'b1;
        @(negedge clk);
        check(!charge_req && !valid, "R6 abort drops charge", int'({charge_req, valid}), 0);
        send_ticks(2);
        release_sys();
        send_ticks(4);
        ramp_hit = 1'b1; @(negedge clk); ramp_hit = 1'b0; @(negedge clk);

        // R9: result held against later activity
        send_ticks(3);
        ramp_hit = 1'b1; @(negedge clk); ramp_hit = 1'b0;
        sys_rst = 1'b1; @(negedge clk); sys_rst = 1'b0;
        repeat (3) @(negedge clk);
        check(valid && !charge_req && period == PW'(9) && !zero_flag && !inf_flag,
              "R9 result held", int'(period), 9);
        check(!(valid && charge_req), "R10 exclusive", int'({valid, charge_req}), 2);

        check(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule